// File: doc/BRIEF.md
# Digital Potentiometer Two-Wire Slave Interface

This block is the serial front end of a digitally controlled resistor. It runs on a fast system clock and oversamples the two-wire bus clock and data lines. It drives the data line only through an open-drain output enable. The slave address is a fixed five-bit prefix followed by two pin-strapped bits, so four of these devices can share one bus.

A write transfer carries the address, then one control byte, then any number of data bytes. The control byte is decoded into one-cycle flag strobes for the wiper controller. Each data byte that follows produces a data strobe. A read transfer has no command byte. The slave streams the current wiper code, then a status byte, and keeps alternating between the two until the master stops acknowledging.

SCL must run at no more than 1/16 of the system clock rate. The line synchronizer and edge detector together add three system clocks of latency.

Top module: `dpot_i2c_slave`

## Requirements
- R1: The slave acknowledges an address byte whose upper seven bits equal binary 01011 followed by `addr_pins[1]` and `addr_pins[0]`, whatever the R/W bit (bit 0, 1 = read). It acknowledges by holding SDA low for the whole ninth clock.
- R2: After an address mismatch the slave never pulls SDA low and issues no strobe until the next START.
- R3: The byte after a write address is the control byte. Its fields are: bit 7 = fuse bank select, bit 6 = shutdown, bit 5 = program, bit 3 = override, bits 2:0 ignored. It is acknowledged, and when bit 4 is 0 `cfg_stb` pulses for exactly one cycle with the four fields on `cfg_bank`, `cfg_shutdown`, `cfg_program` and `cfg_override`.
- R4: A control byte with bit 4 set is still acknowledged but gives no `cfg_stb`. The bytes that follow it are not acknowledged and give no `wr_stb` until the next START. `cfg_stb` and `wr_stb` are never high together.
- R5: Every byte after an accepted control byte in the same transfer is acknowledged and gives a one-cycle `wr_stb` with the byte on `wr_data`.
- R6: In a read, the bytes are sent MSB first, starting with `wiper_code` and then `{fuse_status, 6'b0}`, alternating for as long as the master acknowledges. Each byte is sampled when its first bit is driven. SDA is released for the master's acknowledge bit.
- R7: A master NACK ends a read. The slave then keeps SDA released, even if the master keeps clocking, until the next START.
- R8: A START in any state, including a repeated START, releases SDA and restarts with the address byte. After a repeated START the next write byte is treated as a control byte again.
- R9: A STOP in any state releases SDA. Bytes clocked after it without a START are ignored.
- R10: After reset `sda_oe`, `cfg_stb` and `wr_stb` are 0.
- R11: `sda_oe` changes only in response to an SCL falling edge, a START or a STOP. It never changes while SCL is high during a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 16x SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line, asynchronous |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| addr_pins | input | 2 | Strap bits forming address bits 1:0 |
| wiper_code | input | 8 | Current wiper position for reads |
| fuse_status | input | 2 | Programming status, sent in status byte bits 7:6 |
| cfg_stb | output | 1 | One-cycle strobe for an accepted control byte |
| cfg_bank | output | 1 | Fuse bank select from control bit 7 |
| cfg_shutdown | output | 1 | Shutdown flag from control bit 6 |
| cfg_program | output | 1 | Program flag from control bit 5 |
| cfg_override | output | 1 | Override flag from control bit 3 |
| wr_stb | output | 1 | One-cycle strobe for a data byte |
| wr_data | output | 8 | Data byte for the wiper |

## Verification
Two functions can land in the same bus phase. One is the acknowledge that ends a byte; the other is either the slave releasing SDA, or, in a read, the slave driving the first bit of the next byte.

This is provoked by read sweeps over every status value, with the wiper code changed between bytes. The sampled data is judged against the value present when the next byte loads. It is also provoked by repeated STARTs placed straight after a data acknowledge; these must reopen decoding with a control byte and not a data strobe. An independent monitor also flags any change of `sda_oe` while SCL is high.

// File: rtl/dpot_i2c_pkg.sv
`timescale 1ns/1ps
package dpot_i2c_pkg;
  localparam int BYTE_BITS   = 8;
  localparam int CNT_W       = $clog2(BYTE_BITS + 1);
  localparam int PIN_BITS    = 2;
  localparam int PREFIX_BITS = BYTE_BITS - 1 - PIN_BITS;
  localparam int STATUS_BITS = 2;
  // control byte field positions (decoded by the wiper controller)
  localparam int CB_BANK = 7;
  localparam int CB_SHDN = 6;
  localparam int CB_PROG = 5;
  localparam int CB_ZERO = 4;
  localparam int CB_OVR  = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_ADDR,
    PH_CTRL,
    PH_WDATA,
    PH_READ
  } phase_t;
endpackage

// File: rtl/dpot_i2c_sync.sv
`timescale 1ns/1ps
module dpot_i2c_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  // one flop chain per line; idle bus level is high
  for (genvar g = 0; g < WIDTH; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (rst) chain <= '1;
      else     chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/dpot_i2c_events.sv
`timescale 1ns/1ps
module dpot_i2c_events (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_q;
  assign scl_fall = ~scl_s & scl_q;
  assign start_ev = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_ev  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/dpot_i2c_slave.sv
`timescale 1ns/1ps
module dpot_i2c_slave
  import dpot_i2c_pkg::*;
#(
  parameter int                     SYNC_STAGES = 2,
  parameter logic [PREFIX_BITS-1:0] ADDR_PREFIX = 5'b01011
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   scl_i,
  input  logic                   sda_i,
  output logic                   sda_oe,
  input  logic [PIN_BITS-1:0]    addr_pins,
  input  logic [BYTE_BITS-1:0]   wiper_code,
  input  logic [STATUS_BITS-1:0] fuse_status,
  output logic                   cfg_stb,
  output logic                   cfg_bank,
  output logic                   cfg_shutdown,
  output logic                   cfg_program,
  output logic                   cfg_override,
  output logic                   wr_stb,
  output logic [BYTE_BITS-1:0]   wr_data
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_BITS);

  logic [1:0] lines_s;
  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_ev, stop_ev;

  dpot_i2c_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({scl_i, sda_i}),
    .q   (lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  dpot_i2c_events u_evt (
    .clk      (clk),
    .rst      (rst),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  phase_t               phase, after;
  logic [CNT_W-1:0]     bit_cnt;
  logic                 ack_phase;
  logic                 rd_sel;
  logic [BYTE_BITS-1:0] rx, tx, load_byte;

  // wiper code and status byte alternate in a read
  assign load_byte = rd_sel ? {fuse_status, {(BYTE_BITS-STATUS_BITS){1'b0}}}
                            : wiper_code;

  always_ff @(posedge clk) begin
    cfg_stb <= 1'b0;
    wr_stb  <= 1'b0;
    if (rst) begin
      phase        <= PH_IDLE;
      after        <= PH_IDLE;
      bit_cnt      <= '0;
      ack_phase    <= 1'b0;
      rd_sel       <= 1'b0;
      rx           <= '0;
      tx           <= '0;
      sda_oe       <= 1'b0;
      cfg_bank     <= 1'b0;
      cfg_shutdown <= 1'b0;
      cfg_program  <= 1'b0;
      cfg_override <= 1'b0;
      wr_data      <= '0;
    end else if (start_ev) begin
      phase     <= PH_ADDR;
      bit_cnt   <= '0;
      ack_phase <= 1'b0;
      rd_sel    <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (stop_ev) begin
      phase     <= PH_IDLE;
      ack_phase <= 1'b0;
      sda_oe    <= 1'b0;
    end else if (scl_rise && phase != PH_IDLE) begin
      if (ack_phase) begin
        // master acknowledge slot of a read: high means NACK
        if (phase == PH_READ && sda_s) begin
          phase     <= PH_IDLE;
          ack_phase <= 1'b0;
        end
      end else if (bit_cnt != FULL) begin
        rx      <= {rx[BYTE_BITS-2:0], sda_s};
        bit_cnt <= bit_cnt + 1'b1;
      end
    end else if (scl_fall && phase != PH_IDLE) begin
      if (ack_phase) begin
        ack_phase <= 1'b0;
        bit_cnt   <= '0;
        phase     <= after;
        if (after == PH_READ) begin
          tx     <= load_byte;
          sda_oe <= ~load_byte[BYTE_BITS-1];
          rd_sel <= ~rd_sel;
        end else begin
          sda_oe <= 1'b0;
        end
      end else if (phase == PH_READ) begin
        if (bit_cnt == FULL) begin
          sda_oe    <= 1'b0;
          ack_phase <= 1'b1;
          after     <= PH_READ;
        end else if (bit_cnt != '0) begin
          tx     <= {tx[BYTE_BITS-2:0], 1'b0};
          sda_oe <= ~tx[BYTE_BITS-2];
        end
      end else if (bit_cnt == FULL) begin
        unique case (phase)
          PH_ADDR: begin
            if (rx[BYTE_BITS-1:1] == {ADDR_PREFIX, addr_pins}) begin
              ack_phase <= 1'b1;
              sda_oe    <= 1'b1;
              after     <= rx[0] ? PH_READ : PH_CTRL;
            end else begin
              phase <= PH_IDLE;
            end
          end
          PH_CTRL: begin
            ack_phase <= 1'b1;
            sda_oe    <= 1'b1;
            if (rx[CB_ZERO]) begin
              after <= PH_IDLE;
            end else begin
              after        <= PH_WDATA;
              cfg_stb      <= 1'b1;
              cfg_bank     <= rx[CB_BANK];
              cfg_shutdown <= rx[CB_SHDN];
              cfg_program  <= rx[CB_PROG];
              cfg_override <= rx[CB_OVR];
            end
          end
          PH_WDATA: begin
            ack_phase <= 1'b1;
            sda_oe    <= 1'b1;
            after     <= PH_WDATA;
            wr_stb    <= 1'b1;
            wr_data   <= rx;
          end
          default: phase <= PH_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/dpot_i2c_slave_sva.sv
`timescale 1ns/1ps
module dpot_i2c_slave_sva (
  input logic clk,
  input logic rst,
  input logic sda_oe,
  input logic cfg_stb,
  input logic wr_stb,
  input logic scl_fall,
  input logic start_ev,
  input logic stop_ev
);
  p_oe_moves_low_r11: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> $past(scl_fall || start_ev || stop_ev));

  p_start_release_r8: assert property (@(posedge clk) disable iff (rst)
    start_ev |=> !sda_oe);

  p_stop_release_r9: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);

  p_cfg_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    cfg_stb |=> !cfg_stb);

  p_wr_acked_r5: assert property (@(posedge clk) disable iff (rst)
    wr_stb |-> sda_oe);

  p_one_strobe_r4: assert property (@(posedge clk) disable iff (rst)
    $onehot0({cfg_stb, wr_stb}));
endmodule

bind dpot_i2c_slave dpot_i2c_slave_sva u_sva (
  .clk      (clk),
  .rst      (rst),
  .sda_oe   (sda_oe),
  .cfg_stb  (cfg_stb),
  .wr_stb   (wr_stb),
  .scl_fall (scl_fall),
  .start_ev (start_ev),
  .stop_ev  (stop_ev)
);

// File: tb/dpot_i2c_slave_bench.sv
`timescale 1ns/1ps
module dpot_i2c_slave_bench;
  localparam int HALF = 10;
  localparam int QTR  = 5;
  localparam logic [4:0] PREFIX = 5'b01011;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic [1:0] addr_pins = 2'b10;
  logic [7:0] wiper_code = 8'h80;
  logic [1:0] fuse_status = 2'b00;
  logic       sda_oe, cfg_stb, cfg_bank, cfg_shutdown, cfg_program, cfg_override;
  logic       wr_stb;
  logic [7:0] wr_data;
  logic       sda_bus;

  int n_checks = 0, n_err = 0;
  int cfg_cnt = 0, wr_cnt = 0, viol = 0;
  logic [3:0] cfg_last = '0;
  logic [7:0] wr_last = '0;
  logic       prev_oe = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_bus = m_sda & ~sda_oe;

  dpot_i2c_slave u_dpot_i2c_slave (
    .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus), .sda_oe(sda_oe),
    .addr_pins(addr_pins), .wiper_code(wiper_code), .fuse_status(fuse_status),
    .cfg_stb(cfg_stb), .cfg_bank(cfg_bank), .cfg_shutdown(cfg_shutdown),
    .cfg_program(cfg_program), .cfg_override(cfg_override),
    .wr_stb(wr_stb), .wr_data(wr_data)
  );

  always @(negedge clk) begin
    if (cfg_stb) begin
      cfg_cnt  <= cfg_cnt + 1;
      cfg_last <= {cfg_bank, cfg_shutdown, cfg_program, cfg_override};
    end
    if (wr_stb) begin
      wr_cnt  <= wr_cnt + 1;
      wr_last <= wr_data;
    end
    if (!rst && sda_oe !== prev_oe && m_scl) viol <= viol + 1;
    prev_oe <= sda_oe;
  end

  task automatic check(input string tag, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    wait_clk(QTR); m_sda = b; wait_clk(HALF - QTR);
    m_scl = 1'b1; wait_clk(HALF); m_scl = 1'b0;
  endtask

  task automatic get_bit(output logic b);
    wait_clk(QTR); m_sda = 1'b1; wait_clk(HALF - QTR);
    m_scl = 1'b1; wait_clk(HALF / 2); b = sda_bus;
    wait_clk(HALF - HALF / 2); m_scl = 1'b0;
  endtask

  task automatic bus_start();
    wait_clk(QTR); m_sda = 1'b1; wait_clk(HALF - QTR);
    m_scl = 1'b1; wait_clk(HALF); m_sda = 1'b0; wait_clk(HALF); m_scl = 1'b0;
  endtask

  task automatic bus_stop();
    wait_clk(QTR); m_sda = 1'b0; wait_clk(HALF - QTR);
    m_scl = 1'b1; wait_clk(HALF); m_sda = 1'b1; wait_clk(HALF);
  endtask

  task automatic write_byte(input logic [7:0] b, output logic acked);
    logic x;
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    get_bit(x);
    acked = ~x;
  endtask

  task automatic read_byte(output logic [7:0] b, input logic m_ack);
    logic x;
    for (int i = 7; i >= 0; i--) begin
      get_bit(x);
      b[i] = x;
    end
    put_bit(~m_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end

  initial begin
    logic       ack, ack2;
    logic [7:0] b;
    logic [6:0] dev;
    int         c0, w0;

    wait_clk(5);
    // R10: reset state
    check("R10 sda_oe", sda_oe, 0);
    check("R10 strobes", {cfg_stb, wr_stb}, 0);
    rst = 1'b0;
    wait_clk(5);
    check("R10 idle after reset", sda_oe, 0);

    // R1 / R2: sweep every address with pins = 2'b10
    dev = {PREFIX, addr_pins};
    for (int a = 0; a < 128; a++) begin
      bus_start();
      write_byte({a[6:0], 1'b0}, ack);
      check("R1 address ack", ack, (a[6:0] == dev));
      c0 = cfg_cnt;
      write_byte(8'h00, ack2);
      check("R2 follow-up ack", ack2, (a[6:0] == dev));
      check("R2 follow-up strobe", cfg_cnt - c0, (a[6:0] == dev));
      bus_stop();
    end

    // R1: every pin strap, matching and complementary
    for (int p = 0; p < 4; p++) begin
      addr_pins = p[1:0];
      bus_start();
      write_byte({PREFIX, p[1:0], 1'b0}, ack);
      check("R1 pin match", ack, 1);
      bus_stop();
      bus_start();
      write_byte({PREFIX, ~p[1:0], 1'b1}, ack);
      check("R1 pin mismatch", ack, 0);
      bus_stop();
    end
    addr_pins = 2'b10;

    // R3 / R4 / R5: all control field combinations
    for (int k = 0; k < 32; k++) begin
      logic [7:0] ctl;
      logic [7:0] d;
      logic       ok;
      ctl = {k[4:0], k[2:0]};
      ok  = ~ctl[4];
      d   = 8'(k * 7 + 3);
      c0 = cfg_cnt;
      w0 = wr_cnt;
      bus_start();
      write_byte({PREFIX, 2'b10, 1'b0}, ack);
      write_byte(ctl, ack);
      check("R3 R4 control ack", ack, 1);
      check("R3 R4 control strobe", cfg_cnt - c0, ok);
      if (ok) check("R3 control fields", cfg_last, {ctl[7], ctl[6], ctl[5], ctl[3]});
      write_byte(d, ack);
      check("R4 R5 data ack", ack, ok);
      check("R4 R5 data strobe", wr_cnt - w0, ok);
      if (ok) check("R5 data value", wr_last, d);
      bus_stop();
    end

    // R5: stream every data value in one transfer
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    write_byte(8'h00, ack);
    w0 = wr_cnt;
    for (int v = 0; v < 256; v++) begin
      write_byte(v[7:0] ^ 8'hA5, ack);
      check("R5 stream ack", ack, 1);
      check("R5 stream value", wr_last, v ^ 8'hA5);
    end
    check("R5 stream count", wr_cnt - w0, 256);
    bus_stop();

    // R6 / R7: reads for every status value
    for (int s = 0; s < 4; s++) begin
      logic [7:0] w1, w2;
      w1 = 8'(8'h3C + s * 8'h41);
      w2 = ~w1;
      wiper_code  = w1;
      fuse_status = s[1:0];
      c0 = cfg_cnt;
      w0 = wr_cnt;
      bus_start();
      write_byte({PREFIX, 2'b10, 1'b1}, ack);
      check("R1 read address ack", ack, 1);
      read_byte(b, 1'b1);
      check("R6 wiper byte", b, w1);
      wiper_code = w2;
      read_byte(b, 1'b1);
      check("R6 status byte", b, {s[1:0], 6'b0});
      read_byte(b, 1'b0);
      check("R6 wiper again", b, w2);
      read_byte(b, 1'b0);
      check("R7 released after nack", b, 8'hFF);
      check("R6 no strobes in read", (cfg_cnt - c0) + (wr_cnt - w0), 0);
      bus_stop();
    end

    // R8: repeated start reopens with a control byte
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    write_byte(8'h40, ack);
    write_byte(8'h11, ack);
    c0 = cfg_cnt;
    w0 = wr_cnt;
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    check("R8 readdress ack", ack, 1);
    write_byte(8'h80, ack);
    check("R8 control again", cfg_cnt - c0, 1);
    check("R8 no data strobe", wr_cnt - w0, 0);
    check("R8 bank field", cfg_last, 4'b1000);
    wiper_code = 8'h5E;
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b1}, ack);
    read_byte(b, 1'b0);
    check("R8 read after repeated start", b, 8'h5E);
    bus_stop();

    // R4: rejected control byte, then a fresh START recovers
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    write_byte(8'h10, ack);
    w0 = wr_cnt;
    write_byte(8'h33, ack);
    write_byte(8'h44, ack2);
    check("R4 later bytes unacked", {ack, ack2}, 0);
    check("R4 later bytes no strobe", wr_cnt - w0, 0);
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    write_byte(8'h00, ack);
    write_byte(8'h77, ack);
    check("R4 recover after start", wr_last, 8'h77);
    bus_stop();

    // R9: stop mid-byte, then bytes without START are ignored
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    write_byte(8'h00, ack);
    w0 = wr_cnt;
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1);
    bus_stop();
    check("R9 released at stop", sda_oe, 0);
    wait_clk(HALF); m_scl = 1'b0;
    write_byte(8'h00, ack);
    check("R9 no ack without start", ack, 0);
    check("R9 no strobe without start", wr_cnt - w0, 0);
    bus_start();
    write_byte({PREFIX, 2'b10, 1'b0}, ack);
    check("R9 next transfer ack", ack, 1);
    bus_stop();

    wait_clk(10);
    check("R11 oe steady while scl high", viol, 0);
    $display("  Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule